// File: doc/BRIEF.md
# Address Translation Cache with Two-Level Table Walker

This block turns 32-bit virtual addresses into physical addresses for one requester. It keeps a small fully associative store of recent page mappings. Each stored mapping already spans both levels of the in-memory page table, so a matching request is answered without touching memory. When no stored mapping matches, a hardware walker reads the first-level table entry and then the second-level entry it points to. If both are valid, it stores the resulting mapping and answers. The requester is held off for the whole walk.

Requests and responses use valid/ready handshakes. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the response has been consumed, so only one translation is ever in flight. A response stays on `rsp_valid` with all of its fields frozen until the edge where `rsp_ready` is high. The walker's memory port issues reads with `mem_req_valid`/`mem_req_ready`; the request and its address are held until accepted. Each read is answered later by a single-cycle `mem_rsp_valid` pulse, which the walker always takes.

`base_wr` loads the first-level table location from `base_data[31:12]`. `base_wr` and `flush` both discard every stored mapping. Software changes the base only while no request is in flight.

Top module: `xlate_unit`

## Requirements
- R1: A request whose virtual page number is held in a valid stored entry is answered with that entry's mapping and causes no memory read.
- R2: On a miss the walker first reads address {base[31:12], VA[31:22], 2'b00}. If that entry is valid, it then reads {entry[31:12], VA[21:12], 2'b00}. A successful walk makes exactly two reads.
- R3: Table entries are 32 bits: bit 0 valid, bit 1 cacheable, bit 2 bufferable, bits [31:12] next-table page or physical page. A successful response returns the second-level entry's page in rsp_paddr[31:12], its bit 1 on rsp_cacheable and its bit 2 on rsp_bufferable.
- R4: rsp_paddr[11:0] always equals VA[11:0].
- R5: An invalid entry at either level ends the walk with rsp_fault=1, rsp_paddr, rsp_cacheable and rsp_bufferable all zero, and no fill. A first-level fault makes one read; a repeat of the same page walks again.
- R6: There are 8 entries and no page is ever held twice. A fill goes to the lowest-numbered invalid entry. When all entries are valid, victims are chosen round-robin, starting at entry 0 after each invalidation.
- R7: A base_wr or flush pulse invalidates every entry, so the next request to any page walks using the current base.
- R8: req_ready is high only when idle, and it stays low from the accepting edge until the response is consumed.
- R9: While rsp_valid is high and rsp_ready is low, rsp_valid and every response field hold steady.
- R10: While mem_req_valid is high and mem_req_ready is low, mem_req_valid and mem_req_addr hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_paddr | output | 32 | Physical address |
| rsp_cacheable | output | 1 | Page may be cached |
| rsp_bufferable | output | 1 | Writes to the page may be buffered |
| rsp_fault | output | 1 | Walk hit an invalid table entry |
| base_wr | input | 1 | Load a new first-level table base and invalidate all entries |
| base_data | input | 32 | New base; bits [31:12] are used |
| flush | input | 1 | Invalidate all entries |
| mem_req_valid | output | 1 | Walker read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Single-cycle read data pulse |
| mem_rsp_data | input | 32 | Table entry read |

## Verification
The hardest state to reach is the full store in round-robin mode. There, a fill evicts a mapping the requester still wants, and the choice of victim shows only as an extra walk on a later request. The stimulus first flushes, which resets the victim pointer. It then fills all eight entries with known pages and confirms they all hit. Further misses follow, and the bench predicts which earlier page now costs two reads and which still costs none. Both table levels are computed from the address, so faults at each level and a second context come from the same arithmetic.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int ADDR_W    = 32;
  localparam int PAGE_BITS = 12;
  localparam int LVL_BITS  = 10;
  localparam int PPN_W     = ADDR_W - PAGE_BITS;
  localparam int VPN_W     = ADDR_W - PAGE_BITS;
  localparam int LEVELS    = VPN_W / LVL_BITS;
  localparam int LVL_CNT_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;

  localparam int PTE_VALID = 0;
  localparam int PTE_CACHE = 1;
  localparam int PTE_BUF   = 2;

  typedef struct packed {
    logic [PPN_W-1:0] ppn;
    logic             cacheable;
    logic             bufferable;
  } xlate_t;
endpackage

// File: rtl/xlate_cam.sv
module xlate_cam import xlate_pkg::*; #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = VPN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             hit,
  output xlate_t           hit_data,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  xlate_t           fill_data,
  input  logic             inval
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  xlate_t             data_q [ENTRIES];
  logic [ENTRIES-1:0] hit_vec;
  logic [IDX_W-1:0]   rr_q, free_idx, victim;
  logic               have_free;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign hit_vec[e] = valid_q[e] && (tag_q[e] == lk_tag);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_data = '0;
    for (int e = 0; e < ENTRIES; e++)
      if (hit_vec[e]) hit_data = hit_data | data_q[e];
  end

  always_comb begin
    have_free = 1'b0;
    free_idx  = '0;
    for (int e = ENTRIES - 1; e >= 0; e--)
      if (!valid_q[e]) begin
        have_free = 1'b1;
        free_idx  = IDX_W'(e);
      end
  end

  assign victim = have_free ? free_idx : rr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else if (inval) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else if (fill_en) begin
      valid_q[victim] <= 1'b1;
      if (!have_free)
        rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !inval) begin
      tag_q[victim]  <= fill_tag;
      data_q[victim] <= fill_data;
    end
  end

  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R6
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker import xlate_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VPN_W-1:0]  vpn,
  input  logic [PPN_W-1:0]  base_ppn,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              done,
  output logic              fault,
  output xlate_t            leaf
);
  typedef enum logic [1:0] {W_IDLE, W_REQ, W_WAIT} wst_t;

  wst_t                 st_q;
  logic [VPN_W-1:0]     vpn_q, vpn_sh;
  logic [PPN_W-1:0]     tbl_q;
  logic [LVL_CNT_W-1:0] lvl_q;
  logic [LVL_BITS-1:0]  idx;
  logic                 last, pte_ok;
  logic                 unused_pte_bits;

  assign vpn_sh = vpn_q >> ((LEVELS - 1 - int'(lvl_q)) * LVL_BITS);
  assign idx    = vpn_sh[LVL_BITS-1:0];
  assign last   = (lvl_q == LVL_CNT_W'(LEVELS - 1));
  assign pte_ok = mem_rsp_data[PTE_VALID];
  assign unused_pte_bits = ^mem_rsp_data[PAGE_BITS-1:PTE_BUF+1];

  assign mem_req_valid = (st_q == W_REQ);
  assign mem_req_addr  = {tbl_q, idx, 2'b00};

  assign done  = (st_q == W_WAIT) && mem_rsp_valid && (!pte_ok || last);
  assign fault = !pte_ok;
  assign leaf  = '{ppn:        mem_rsp_data[ADDR_W-1:PAGE_BITS],
                   cacheable:  mem_rsp_data[PTE_CACHE],
                   bufferable: mem_rsp_data[PTE_BUF]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= W_IDLE;
      vpn_q <= '0;
      tbl_q <= '0;
      lvl_q <= '0;
    end else begin
      case (st_q)
        W_IDLE: if (start) begin
          vpn_q <= vpn;
          tbl_q <= base_ppn;
          lvl_q <= '0;
          st_q  <= W_REQ;
        end
        W_REQ: if (mem_req_ready) st_q <= W_WAIT;
        W_WAIT: if (mem_rsp_valid) begin
          if (!pte_ok || last) st_q <= W_IDLE;
          else begin
            tbl_q <= mem_rsp_data[ADDR_W-1:PAGE_BITS];
            lvl_q <= lvl_q + 1'b1;
            st_q  <= W_REQ;
          end
        end
        default: st_q <= W_IDLE;
      endcase
    end
  end

  AST_MREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R10
endmodule

// File: rtl/xlate_unit.sv
module xlate_unit import xlate_pkg::*; #(
  parameter int ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_cacheable,
  output logic              rsp_bufferable,
  output logic              rsp_fault,
  input  logic              base_wr,
  input  logic [ADDR_W-1:0] base_data,
  input  logic              flush,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data
);
  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_WALK, S_RESP} st_t;

  st_t              st_q;
  logic [ADDR_W-1:0] va_q;
  logic [PPN_W-1:0] base_q;
  xlate_t           res_q, hit_data, walk_leaf;
  logic             flt_q, hit, walk_start, walk_done, walk_fault, fill_en;
  logic             unused_base_low;

  assign unused_base_low = ^base_data[PAGE_BITS-1:0];

  assign req_ready  = (st_q == S_IDLE);
  assign rsp_valid  = (st_q == S_RESP);
  assign walk_start = (st_q == S_LOOK) && !hit;
  assign fill_en    = (st_q == S_WALK) && walk_done && !walk_fault;

  assign rsp_paddr      = {res_q.ppn, va_q[PAGE_BITS-1:0]};
  assign rsp_cacheable  = res_q.cacheable;
  assign rsp_bufferable = res_q.bufferable;
  assign rsp_fault      = flt_q;

  xlate_cam #(.ENTRIES(ENTRIES), .TAG_W(VPN_W)) i_cam (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_tag    (va_q[ADDR_W-1:PAGE_BITS]),
    .hit       (hit),
    .hit_data  (hit_data),
    .fill_en   (fill_en),
    .fill_tag  (va_q[ADDR_W-1:PAGE_BITS]),
    .fill_data (walk_leaf),
    .inval     (base_wr || flush)
  );

  xlate_walker i_walk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (walk_start),
    .vpn           (va_q[ADDR_W-1:PAGE_BITS]),
    .base_ppn      (base_q),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .done          (walk_done),
    .fault         (walk_fault),
    .leaf          (walk_leaf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) base_q <= '0;
    else if (base_wr) base_q <= base_data[ADDR_W-1:PAGE_BITS];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      va_q  <= '0;
      res_q <= '0;
      flt_q <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (req_valid) begin
          va_q <= req_vaddr;
          st_q <= S_LOOK;
        end
        S_LOOK: if (hit) begin
          res_q <= hit_data;
          flt_q <= 1'b0;
          st_q  <= S_RESP;
        end else st_q <= S_WALK;
        S_WALK: if (walk_done) begin
          res_q <= walk_fault ? '0 : walk_leaf;
          flt_q <= walk_fault;
          st_q  <= S_RESP;
        end
        S_RESP: if (rsp_ready) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr)
      && $stable(rsp_fault) && $stable(rsp_cacheable)); // R9
  AST_STALL_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready); // R8
  AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> !rsp_cacheable && !rsp_bufferable
      && (rsp_paddr[ADDR_W-1:PAGE_BITS] == '0)); // R5
  AST_NO_MEM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid); // R1
endmodule

// File: tb/test_xlate_unit.sv
`timescale 1ns/1ps
module test_xlate_unit;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, req_valid, req_ready, rsp_valid, rsp_ready;
  logic rsp_cacheable, rsp_bufferable, rsp_fault;
  logic base_wr, flush, mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [31:0] req_vaddr, rsp_paddr, base_data, mem_req_addr, mem_rsp_data;

  xlate_unit i_xlate_unit (.*);

  int total = 0, bad = 0, reads = 0, cyc = 0;
  logic pend, prev_wait;
  int cnt;
  logic [31:0] maddr, prev_addr;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [19:0] leaf_ppn(int i, int j, int c);
    return 20'(i * 37 + j * 11 + c * 21845 + 74565);
  endfunction

  function automatic logic [31:0] pt_read(logic [31:0] a);
    int c, i, j, off;
    if (a[31:12] == 20'h00010 || a[31:12] == 20'h00020) begin
      c = (a[31:12] == 20'h00020) ? 1 : 0;
      i = int'(a[11:2]);
      if (i % 4 == 3) return 32'h0;
      return {20'h80000 + 20'(c * 1024) + 20'(i), 12'h001};
    end
    if (a[31:12] >= 20'h80000 && a[31:12] < 20'h80800) begin
      off = int'(a[31:12] - 20'h80000);
      c = off / 1024; i = off % 1024; j = int'(a[11:2]);
      if (j % 5 == 4) return 32'h0;
      return {leaf_ppn(i, j, c), 9'h0, 1'(i[0] ^ c[0]), 1'(j[0]), 1'b1};
    end
    return 32'h0;
  endfunction

  // memory model with variable acceptance and latency
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      pend <= 0; cnt <= 0; mem_rsp_valid <= 0; mem_rsp_data <= 0;
      mem_req_ready <= 0; prev_wait <= 0; prev_addr <= 0; maddr <= 0;
    end else begin
      if (prev_wait)
        chk(mem_req_valid && mem_req_addr == prev_addr, "R10", "mem req hold",
            mem_req_addr, prev_addr);
      prev_wait <= mem_req_valid && !mem_req_ready;
      prev_addr <= mem_req_addr;
      if (mem_req_valid && mem_req_ready) begin
        pend <= 1; maddr <= mem_req_addr; cnt <= cyc % 4; reads <= reads + 1;
        mem_req_ready <= 0; mem_rsp_valid <= 0;
      end else begin
        if (pend && cnt == 0) begin
          mem_rsp_valid <= 1; mem_rsp_data <= pt_read(maddr); pend <= 0;
        end else begin
          mem_rsp_valid <= 0;
          if (pend) cnt <= cnt - 1;
        end
        mem_req_ready <= !pend && (cyc % 3 != 1);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic bit is_fault(logic [31:0] va);
    return (int'(va[31:22]) % 4 == 3) || (int'(va[21:12]) % 5 == 4);
  endfunction

  task automatic xlate(input logic [31:0] va, input int c, input bit exp_hit, input int hold);
    int i, j, r0, exp_reads;
    bit f1, flt, rdy, stall_bad, hold_bad;
    logic [31:0] exp_pa, first_pa;
    logic ec, eb;
    i = int'(va[31:22]); j = int'(va[21:12]);
    f1 = (i % 4 == 3); flt = is_fault(va);
    exp_reads = exp_hit ? 0 : (f1 ? 1 : 2);
    exp_pa = flt ? {20'h0, va[11:0]} : {leaf_ppn(i, j, c), va[11:0]};
    ec = flt ? 1'b0 : 1'(j % 2);
    eb = flt ? 1'b0 : 1'((i % 2) ^ c);
    r0 = reads; stall_bad = 0; hold_bad = 0;
    @(negedge clk); req_valid = 1; req_vaddr = va; rsp_ready = 0;
    forever begin
      rdy = req_ready;
      @(posedge clk);
      if (rdy) break;
      @(negedge clk);
    end
    @(negedge clk); req_valid = 0;
    while (!rsp_valid) begin
      if (req_ready) stall_bad = 1;
      @(negedge clk);
    end
    first_pa = rsp_paddr;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      if (!rsp_valid || rsp_paddr != first_pa || req_ready) hold_bad = 1;
    end
    chk(rsp_paddr[31:12] == exp_pa[31:12], "R3", "ppn", rsp_paddr, exp_pa);
    chk(rsp_paddr[11:0] == va[11:0], "R4", "offset", rsp_paddr, exp_pa);
    chk(rsp_cacheable == ec && rsp_bufferable == eb, "R3", "attr",
        {rsp_cacheable, rsp_bufferable}, {ec, eb});
    chk(rsp_fault == flt, "R5", "fault", rsp_fault, flt);
    chk(reads - r0 == exp_reads, exp_hit ? "R1" : "R2", "reads", reads - r0, exp_reads);
    chk(!stall_bad && !req_ready, "R8", "stall", stall_bad, 0);
    if (hold > 0) chk(!hold_bad, "R9", "rsp hold", hold_bad, 0);
    rsp_ready = 1;
    @(negedge clk); rsp_ready = 0;
  endtask

  task automatic pulse_base(input logic [31:0] b);
    @(negedge clk); base_wr = 1; base_data = b;
    @(negedge clk); base_wr = 0;
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
  endtask

  function automatic logic [31:0] pg(int i);
    return {10'(i), 10'd0, 12'h0a4};
  endfunction

  initial begin
    int pl [9];
    int j;
    logic [31:0] va;
    pl = '{0, 1, 2, 4, 5, 6, 8, 9, 10};
    rst_n = 0; req_valid = 0; req_vaddr = 0; rsp_ready = 0;
    base_wr = 0; base_data = 0; flush = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    chk(req_ready == 1, "R8", "reset ready", req_ready, 1);
    chk(rsp_valid == 0, "R9", "reset rsp_valid", rsp_valid, 0);
    chk(mem_req_valid == 0, "R10", "reset mem_req_valid", mem_req_valid, 0);

    pulse_base(32'h0001_0000);
    // sweep: miss then repeat (R1 R2 R3 R4 R5)
    for (int i = 0; i < 12; i++) begin
      for (int jj = 0; jj < 4; jj++) begin
        j = (jj == 0) ? 0 : (jj == 1) ? 1 : (jj == 2) ? 4 : 7;
        va = {10'(i), 10'(j), 12'(i * j * 13 + 5)};
        xlate(va, 0, 0, jj);
        xlate(va ^ 32'h0000_07ff, 0, !is_fault(va), 0);
      end
    end

    // R6 replacement order
    pulse_flush();
    for (int k = 0; k < 8; k++) xlate(pg(pl[k]), 0, 0, 0);
    for (int k = 0; k < 8; k++) xlate(pg(pl[k]), 0, 1, 0);
    xlate(pg(pl[8]), 0, 0, 0);   // R6 evicts entry 0
    xlate(pg(pl[1]), 0, 1, 0);
    xlate(pg(pl[0]), 0, 0, 0);   // R6 evicts entry 1
    xlate(pg(pl[1]), 0, 0, 0);   // R6 evicts entry 2
    xlate(pg(pl[3]), 0, 1, 0);
    xlate(pg(pl[2]), 0, 0, 0);   // R6 evicts entry 3
    xlate(pg(pl[4]), 0, 1, 2);

    // R7 context switch and flush
    pulse_base(32'h0002_0000);
    xlate(pg(pl[4]), 1, 0, 0);
    xlate(pg(pl[4]), 1, 1, 1);
    xlate(pg(pl[8]), 1, 0, 0);
    pulse_flush();
    xlate(pg(pl[4]), 1, 0, 3);
    xlate(pg(pl[8]), 1, 0, 0);

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule